// File: doc/BRIEF.md
# Flag-Generating Add/Logic Unit

This block is one integer execution slice. It performs plain addition, addition with an incoming carry, or a bitwise AND, at a destination width of 8, 16, 32 or 64 bits. The second source is either a full register operand or an immediate. The immediate is sign-extended from its own encoded width to the destination width. Besides the width-truncated result, the unit produces six status flags: unsigned carry, signed overflow, sign, zero, the auxiliary carry out of bit 3, and the parity of the low byte.

An issue stage presents one operation per strobe. The unit registers the result and flags and presents them on the next clock edge with a one-cycle valid pulse. Between strobes the last result and flags stay on the outputs.

Top module: `flagalu_top`

## Requirements
- R1: A synchronous active-high reset sets out_valid, result and all six flags to 0.
- R2: out_valid is 1 in the cycle after a clock edge that samples in_valid high, and 0 otherwise. When in_valid is low, result and the flags keep their previous values.
- R3: size_sel selects the destination width: 00 for 8 bits, 01 for 16, 10 for 32 and 11 for 64. Source bits above that width are ignored, and result bits above it are 0.
- R4: op_sel 00 (plain add) returns the width-truncated sum of the two sources. carry_in has no effect.
- R5: op_sel 01 (add with carry) returns the width-truncated sum of the two sources plus carry_in.
- R6: When imm_use is 1, the second source is imm_val instead of src_b. imm_len gives its width: 00 for 8 bits, 01 for 16, 10 or 11 for 32. Its top bit is copied into every bit up to the destination width, so for a 64-bit destination the widest immediate is 32 bits.
- R7: op_sel 10 or 11 returns the bitwise AND of the two sources. For these ops flag_of, flag_cf and flag_af are 0.
- R8: For the two add ops, flag_cf is the carry out of the top bit of the selected width. flag_of is 1 when both sources have the same sign bit and the result's sign bit differs from it.
- R9: flag_sf equals the result's top bit at the selected width. flag_zf is 1 exactly when the truncated result is zero.
- R10: For the two add ops, flag_af is the carry out of bit 3 into bit 4. For every op, flag_pf is 1 when the low 8 result bits hold an even number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 add, 01 add with carry, 10/11 AND |
| size_sel | input | 2 | Destination width code |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source, register form |
| imm_val | input | 32 | Immediate value |
| imm_len | input | 2 | Immediate width code |
| imm_use | input | 1 | 1 selects the immediate as second source |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid pulse |
| result | output | 64 | Width-truncated result |
| flag_of | output | 1 | Signed overflow |
| flag_sf | output | 1 | Sign |
| flag_zf | output | 1 | Zero |
| flag_af | output | 1 | Carry out of bit 3 |
| flag_pf | output | 1 | Even parity of low byte |
| flag_cf | output | 1 | Unsigned carry out |

## Verification
Some cases are hard to reach from the ports. One is a 64-bit add where a sign-extended 32-bit immediate produces a carry out, a zero result and no signed overflow, all at once. Another is a narrow add whose sources carry non-zero bits above the selected width. Random 64-bit values almost never land on these, so the stimulus mixes directed corner operations with random draws taken from a biased pool. The pool holds zero, all ones, and the patterns just below and at each sign boundary. Immediate lengths and destination sizes are crossed independently, so a short immediate is often extended into a wide destination.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    parameter int DATA_W    = 64;
    parameter int IMM_W     = 32;
    parameter int BYTE_W    = 8;
    localparam int NUM_SIZES = $clog2(DATA_W / BYTE_W) + 1;
    localparam int NUM_IMMS  = $clog2(IMM_W / BYTE_W) + 1;
    localparam int SIZE_CW   = $clog2(NUM_SIZES);
    localparam int IMM_CW    = 2;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_AND  = 2'b10,
        OP_AND2 = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic              of;
        logic              sf;
        logic              zf;
        logic              af;
        logic              pf;
        logic              cf;
    } alu_flags_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        alu_flags_t        flags;
    } alu_state_t;

endpackage

// File: rtl/flagalu_operand.sv
module flagalu_operand
    import flagalu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [SIZE_CW-1:0] size_sel,
    input  logic [DW-1:0]      src_a,
    input  logic [DW-1:0]      src_b,
    input  logic [IW-1:0]      imm_val,
    input  logic [IMM_CW-1:0]  imm_len,
    input  logic               imm_use,
    output logic [DW-1:0]      width_mask,
    output logic [DW-1:0]      opnd_a,
    output logic [DW-1:0]      opnd_b
);

    logic [DW-1:0] mask_tab [NUM_SIZES];
    logic [DW-1:0] ext_tab  [NUM_IMMS];
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] b_pick;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_mask
        localparam int W = BYTE_W << k;
        if (W >= DW) begin : g_full
            assign mask_tab[k] = {DW{1'b1}};
        end else begin : g_part
            assign mask_tab[k] = {{(DW - W){1'b0}}, {W{1'b1}}};
        end
    end

    for (genvar j = 0; j < NUM_IMMS; j++) begin : g_ext
        localparam int EW = BYTE_W << j;
        assign ext_tab[j] = {{(DW - EW){imm_val[EW-1]}}, imm_val[EW-1:0]};
    end

    always_comb begin
        if (int'(imm_len) >= NUM_IMMS) begin
            imm_ext = ext_tab[NUM_IMMS-1];
        end else begin
            imm_ext = ext_tab[imm_len];
        end
        b_pick     = imm_use ? imm_ext : src_b;
        width_mask = mask_tab[size_sel];
        opnd_a     = src_a & width_mask;
        opnd_b     = b_pick & width_mask;
    end

endmodule

// File: rtl/flagalu_adder.sv
module flagalu_adder
    import flagalu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          cin,
    output logic [DW:0]   sum,
    output logic [DW-1:0] carry_vec
);

    always_comb begin
        sum       = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, cin};
        carry_vec = opnd_a ^ opnd_b ^ sum[DW-1:0];
    end

endmodule

// File: rtl/flagalu_flags.sv
module flagalu_flags
    import flagalu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [SIZE_CW-1:0] size_sel,
    input  logic               logic_op,
    input  logic [DW-1:0]      width_mask,
    input  logic [DW-1:0]      opnd_a,
    input  logic [DW-1:0]      opnd_b,
    input  logic [DW:0]        sum,
    input  logic [DW-1:0]      carry_vec,
    output logic [DW-1:0]      res,
    output alu_flags_t         flags
);

    logic [NUM_SIZES-1:0] cf_tap;
    logic [NUM_SIZES-1:0] of_tap;
    logic [NUM_SIZES-1:0] sf_tap;

    always_comb begin
        if (logic_op) begin
            res = opnd_a & opnd_b;
        end else begin
            res = sum[DW-1:0] & width_mask;
        end
    end

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_tap
        localparam int W = BYTE_W << k;
        assign cf_tap[k] = sum[W];
        assign of_tap[k] = (opnd_a[W-1] == opnd_b[W-1]) && (sum[W-1] != opnd_a[W-1]);
        assign sf_tap[k] = res[W-1];
    end

    always_comb begin
        flags.sf = sf_tap[size_sel];
        flags.zf = ~|res;
        flags.pf = ~^res[BYTE_W-1:0];
        if (logic_op) begin
            flags.cf = 1'b0;
            flags.of = 1'b0;
            flags.af = 1'b0;
        end else begin
            flags.cf = cf_tap[size_sel];
            flags.of = of_tap[size_sel];
            flags.af = carry_vec[4];
        end
    end

endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
    import flagalu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  op_sel,
    input  logic [1:0]  size_sel,
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    input  logic [31:0] imm_val,
    input  logic [1:0]  imm_len,
    input  logic        imm_use,
    input  logic        carry_in,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        flag_of,
    output logic        flag_sf,
    output logic        flag_zf,
    output logic        flag_af,
    output logic        flag_pf,
    output logic        flag_cf
);

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] carry_vec;
    logic [DATA_W-1:0] res_c;
    alu_flags_t        flags_c;
    logic              logic_op;
    logic              cin_eff;
    alu_state_t        st_d;
    alu_state_t        st_q;

    assign logic_op = op_sel[1];
    assign cin_eff  = (alu_op_e'(op_sel) == OP_ADDC) ? carry_in : 1'b0;

    flagalu_operand u_opnd (
        .size_sel   (size_sel),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm_val    (imm_val),
        .imm_len    (imm_len),
        .imm_use    (imm_use),
        .width_mask (width_mask),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    flagalu_adder u_add (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .cin       (cin_eff),
        .sum       (sum),
        .carry_vec (carry_vec)
    );

    flagalu_flags u_flg (
        .size_sel   (size_sel),
        .logic_op   (logic_op),
        .width_mask (width_mask),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .sum        (sum),
        .carry_vec  (carry_vec),
        .res        (res_c),
        .flags      (flags_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            st_d.data  = res_c;
            st_d.flags = flags_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;
    assign flag_of   = st_q.flags.of;
    assign flag_sf   = st_q.flags.sf;
    assign flag_zf   = st_q.flags.zf;
    assign flag_af   = st_q.flags.af;
    assign flag_pf   = st_q.flags.pf;
    assign flag_cf   = st_q.flags.cf;

endmodule

// File: rtl/flagalu_checker.sv
module flagalu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  op_sel,
    input logic [1:0]  size_sel,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        flag_of,
    input logic        flag_sf,
    input logic        flag_zf,
    input logic        flag_af,
    input logic        flag_pf,
    input logic        flag_cf
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && result == 64'd0 && !flag_cf && !flag_zf)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> (!out_valid && $stable(result))); // R2

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size_sel) == 2'b00) |-> (result[63:8] == 56'd0)); // R3

    AST_MID_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size_sel) == 2'b10) |-> (result[63:32] == 32'd0)); // R3

    AST_AND_QUIET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_sel[1])) |-> (!flag_of && !flag_cf && !flag_af)); // R7

    AST_SIGN_WIDE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(size_sel) == 2'b11) |-> (flag_sf == result[63])); // R9

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_zf == (result == 64'd0))); // R9

    AST_PARITY_LOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_pf == ~^result[7:0])); // R10

endmodule

bind flagalu_top flagalu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .size_sel  (size_sel),
    .out_valid (out_valid),
    .result    (result),
    .flag_of   (flag_of),
    .flag_sf   (flag_sf),
    .flag_zf   (flag_zf),
    .flag_af   (flag_af),
    .flag_pf   (flag_pf),
    .flag_cf   (flag_cf)
);

// File: tb/flagalu_top_test.sv
module flagalu_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [1:0]  size_sel = 2'b00;
    logic [63:0] src_a = 64'd0;
    logic [63:0] src_b = 64'd0;
    logic [31:0] imm_val = 32'd0;
    logic [1:0]  imm_len = 2'b00;
    logic        imm_use = 1'b0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf;

    int checks = 0;
    int fails  = 0;

    logic        mdl_valid = 1'b0;
    logic [63:0] mdl_res   = 64'd0;
    logic [5:0]  mdl_flg   = 6'd0;
    logic [63:0] mdl_mask  = 64'hFF;
    string       mdl_tag   = "R1";

    always #4 clk = ~clk;

    flagalu_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
        .imm_len(imm_len), .imm_use(imm_use), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .flag_of(flag_of),
        .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_af(flag_af),
        .flag_pf(flag_pf), .flag_cf(flag_cf)
    );

    function automatic void ref_op(
        input logic [1:0] op, input logic [1:0] sz, input logic [63:0] a,
        input logic [63:0] b, input logic [31:0] imm, input logic [1:0] ilen,
        input logic iuse, input logic cin,
        output logic [63:0] res, output logic [5:0] flg, output logic [63:0] msk);
        int w, iw;
        logic [63:0] ext, am, bm;
        logic [64:0] full;
        logic of, sf, zf, af, pf, cf;
        w   = 8 << sz;
        msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        iw  = (ilen == 2'b00) ? 8 : (ilen == 2'b01) ? 16 : 32;
        ext = {32'd0, imm} & ((64'd1 << iw) - 64'd1);
        if (imm[iw-1]) ext = ext | ~((64'd1 << iw) - 64'd1);
        am = a & msk;
        bm = (iuse ? ext : b) & msk;
        if (op[1]) begin
            res = am & bm;
            of = 0; cf = 0; af = 0;
        end else begin
            full = {1'b0, am} + {1'b0, bm} + ((op == 2'b01 && cin) ? 65'd1 : 65'd0);
            res  = full[63:0] & msk;
            cf   = full[w];
            of   = (am[w-1] == bm[w-1]) && (res[w-1] != am[w-1]);
            af   = (am[4] ^ bm[4] ^ res[4]);
        end
        sf  = res[w-1];
        zf  = (res == 64'd0);
        pf  = ~^res[7:0];
        flg = {of, sf, zf, af, pf, cf};
    endfunction

    always @(posedge clk) begin
        logic [63:0] r, m;
        logic [5:0]  f;
        if (rst) begin
            mdl_valid <= 1'b0;
            mdl_res   <= 64'd0;
            mdl_flg   <= 6'd0;
            mdl_tag   <= "R1";
        end else begin
            mdl_valid <= in_valid;
            if (in_valid) begin
                ref_op(op_sel, size_sel, src_a, src_b, imm_val, imm_len, imm_use,
                       carry_in, r, f, m);
                mdl_res  <= r;
                mdl_flg  <= f;
                mdl_mask <= m;
                mdl_tag  <= imm_use ? "R6" : op_sel[1] ? "R7" :
                            (op_sel == 2'b01) ? "R5" : "R4";
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_now();
        check("R2 out_valid", {63'd0, out_valid}, {63'd0, mdl_valid});
        check({mdl_tag, " result"}, result, mdl_res);
        check("R3 upper bits", result & ~mdl_mask, 64'd0);
        check("R8 of/cf", {62'd0, flag_of, flag_cf}, {62'd0, mdl_flg[5], mdl_flg[0]});
        check("R9 sf/zf", {62'd0, flag_sf, flag_zf}, {62'd0, mdl_flg[4], mdl_flg[3]});
        check("R10 af/pf", {62'd0, flag_af, flag_pf}, {62'd0, mdl_flg[2], mdl_flg[1]});
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] b, input logic [31:0] imm, input logic [1:0] il,
                         input logic iu, input logic ci);
        in_valid = 1'b1; op_sel = op; size_sel = sz; src_a = a; src_b = b;
        imm_val = imm; imm_len = il; imm_use = iu; carry_in = ci;
        @(negedge clk);
        compare_now();
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [63:0] r, input logic [5:0] f);
        check({tag, " directed result"}, result, r);
        check({tag, " directed flags"}, {58'd0, flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf},
              {58'd0, f});
    endtask

    function automatic logic [63:0] pick();
        case ($urandom % 7)
            0: return 64'd0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_8000_8080;
            3: return 64'h7FFF_FFFF_7FFF_7F7F;
            4: return {60'd0, 4'($urandom)};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset flags", {58'd0, flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        compare_now();

        // R8 signed overflow at 8 bits: 7F + 01 -> 80, OF SF AF, odd parity
        issue(2'b00, 2'b00, 64'h7F, 64'h01, 0, 0, 0, 0);
        expect_out("R8", 64'h80, 6'b110100);
        // R3: upper source bits ignored; FF + 01 at 8 bits -> 00 ZF AF PF CF
        issue(2'b00, 2'b00, 64'hABCD_00FF, 64'h1200_0001, 0, 0, 0, 1);
        expect_out("R3", 64'h00, 6'b001111);
        // R4: carry_in has no effect on plain add
        issue(2'b00, 2'b01, 64'h0001, 64'h0001, 0, 0, 0, 1);
        expect_out("R4", 64'h0002, 6'b000000);
        // R5: carry_in added; FFFF + 0 + 1 at 16 bits -> 0000 with carry
        issue(2'b01, 2'b01, 64'hFFFF, 64'h0, 0, 0, 0, 1);
        expect_out("R5", 64'h0000, 6'b001111);
        // R6: 8-bit immediate 80 extended to 64 bits plus zero
        issue(2'b00, 2'b11, 64'h0, 64'h5, 32'h80, 2'b00, 1, 0);
        expect_out("R6", 64'hFFFF_FFFF_FFFF_FF80, 6'b010000);
        // R6: 32-bit immediate FFFFFFFF extended to 64 bits plus one -> zero with carry
        issue(2'b00, 2'b11, 64'h1, 64'h0, 32'hFFFF_FFFF, 2'b10, 1, 0);
        expect_out("R6", 64'h0, 6'b001111);
        // R7: AND with op 11, flags OF CF AF cleared
        issue(2'b11, 2'b10, 64'hF0F0_8000_00FF, 64'hFFFF_8000_0F0F, 0, 0, 0, 1);
        expect_out("R7", 64'h8000_000F, 6'b010010);
        // R2: idle cycles with changing inputs must not disturb held output
        src_a = 64'h1234; src_b = 64'h5678; op_sel = 2'b01;
        @(negedge clk);
        compare_now();
        check("R2 hold", result, 64'h8000_000F);

        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) begin
                src_a = pick();
                @(negedge clk);
                compare_now();
            end else begin
                issue(2'($urandom), 2'($urandom), pick(), pick(),
                      32'(pick()), 2'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        rst = 1'b1;
        @(negedge clk);
        check("R1 late reset", {63'd0, out_valid} | result, 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule